// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The controller gathers up to 96 level-sensitive interrupt inputs and presents two request outputs to a processor: a normal request and a fast request. The inputs are grouped in banks of 32. Per bank, software can read the raw input levels, and it can enable or disable each source through a mask with separate set and clear write aliases. It can also inject a source through a software-interrupt register, and read which sources are pending on each path. Each source has a line register that holds a 6-bit priority and the choice of output path.

For each path the controller picks the eligible pending source with the best priority and latches it. It raises the path's output while the winner is held. The reported source number stays frozen until software acknowledges the path through the control register. After the acknowledge, the controller sorts again from the state present at that time. A priority threshold can suppress low-urgency sources. A soft reset returns all programmable state to its reset values and reports completion in a status bit.

The register port has no handshake. It accepts one access on every clock, a write when `reg_wr_i` is high, and never stalls. No path in the block carries stream data, so there is no valid/ready interface.

Top module: `irqc_top`

## Requirements
- R1: Source n maps to bank n/32, bit n%32. Bank b's registers start at byte address 0x40 + 0x20*b. The raw register (bank offset 0x00) reads the live input levels whether or not they are masked. Every register read returns the value for the address presented, one clock later.
- R2: The mask register (bank offset 0x04) uses 1 = masked and resets to all ones. A masked source never appears in a pending register and never drives an output.
- R3: Writing the mask-clear alias (bank offset 0x08) clears the mask bits that are written as 1. Writing the mask-set alias (bank offset 0x0C) sets the mask bits that are written as 1. Bits written as 0 are unchanged in both cases. Both aliases read as 0.
- R4: Writing the software set register (bank offset 0x10) sets bits, and the same offset reads them back. Writing the software clear register (bank offset 0x14) clears the bits written as 1. A set bit acts as an active input until it is cleared.
- R5: Pending-normal (bank offset 0x18) and pending-fast (bank offset 0x1C) show sources that are active, unmasked and routed to that path. The threshold does not affect them.
- R6: The line register for source n is at 0x100 + 4n. Bits 7:2 hold the priority. Bit 0 selects the fast path (1) or the normal path (0). All other bits read 0.
- R7: The winner is the eligible source with the smallest priority value. On a tie, the lower source number wins. Active-normal (0x08) and active-fast (0x0C) report the winner's number in bits 6:0, and 127 when no winner is latched.
- R8: The threshold register (0x14, 8 bits) resets to 0xFF, which disables filtering. Any other value makes a source eligible only if its priority is strictly below the threshold.
- R9: Once latched, a winner and its output stay unchanged while no acknowledge is written, even if inputs, masks or priorities change.
- R10: Writing 1 to control (0x10) bit 0 acknowledges the normal path, and bit 1 acknowledges the fast path. The output drops in the cycle after the write. If a source is still eligible, the output rises again one clock later.
- R11: With no winner held, an eligible source is latched at the next clock edge. `irq_o`/`fiq_o` are high exactly while a winner is held.
- R12: Writing 1 to config (0x00) bit 1 starts a soft reset. Status (0x04) bit 0 reads 0 on a read issued in the cycle right after the write, and 1 afterwards. Mask, software, threshold, line and winner state return to their reset values.
- R13: After reset both outputs are low, the status bit reads 1, line registers read 0 and both active registers read 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level interrupt inputs, one per source |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 10 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one clock after the address |
| irq_o | output | 1 | Normal-path request, high while a winner is held |
| fiq_o | output | 1 | Fast-path request, high while a winner is held |

## Verification
Some properties are checked every cycle by assertions: a held winner stays frozen until its acknowledge, the output drops right after an acknowledge, and an eligible source is picked up on the very next edge. The assertions also check that a newly latched winner passed the threshold, that masked sources never reach a pending bit, and that a soft reset lasts one cycle and clears both outputs. Other behaviour needs the bench's scenarios, because it depends on the value that was chosen rather than on when it was chosen. This covers lowest-priority-value arbitration with tie-breaking by source number, the exact threshold boundary, routing to the fast path, the alias write semantics and the register read-back values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W       = 32;
  localparam int BANK_W      = 32;
  localparam int OFS_CFG     = 'h00;
  localparam int OFS_STAT    = 'h04;
  localparam int OFS_ACT_IRQ = 'h08;
  localparam int OFS_ACT_FIQ = 'h0C;
  localparam int OFS_CTRL    = 'h10;
  localparam int OFS_THR     = 'h14;
  localparam int BANK_BASE   = 'h40;
  localparam int BANK_STRIDE = 'h20;
  localparam int LINE_BASE   = 'h100;

  // word slot inside a bank window
  typedef enum logic [2:0] {
    SUB_RAW  = 3'd0,
    SUB_MASK = 3'd1,
    SUB_MCLR = 3'd2,
    SUB_MSET = 3'd3,
    SUB_SWI  = 3'd4,
    SUB_SCLR = 3'd5,
    SUB_PIRQ = 3'd6,
    SUB_PFIQ = 3'd7
  } bank_sub_e;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic [W-1:0] line_i,
  input  logic      we_i,
  input  bank_sub_e sub_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] swi_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] mask_q, swi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else if (clr) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else if (we_i) begin
      unique case (sub_i)
        SUB_MCLR: mask_q <= mask_q & ~wdata_i;
        SUB_MSET: mask_q <= mask_q | wdata_i;
        SUB_SWI:  swi_q  <= swi_q | wdata_i;
        SUB_SCLR: swi_q  <= swi_q & ~wdata_i;
        default:  ;
      endcase
    end
  end

  assign mask_o   = mask_q;
  assign swi_o    = swi_q;
  assign active_o = line_i | swi_q;
endmodule

// File: rtl/irqc_sorter.sv
module irqc_sorter #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int ID_W   = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [N-1:0]           req_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  input  logic                   ack_i,
  output logic                   valid_o,
  output logic [ID_W-1:0]        id_o,
  output logic [PRIO_W-1:0]      prio_o
);
  localparam logic [ID_W-1:0] NONE_ID = '1;

  logic              found;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;

  // strict compare keeps the lower index on equal priority
  always_comb begin
    found     = 1'b0;
    best_id   = NONE_ID;
    best_prio = '1;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!found || prio_i[i] < best_prio)) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio_i[i];
      end
    end
  end

  logic              valid_q;
  logic [ID_W-1:0]   id_q;
  logic [PRIO_W-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      id_q    <= NONE_ID;
      prio_q  <= '0;
    end else if (clr || ack_i) begin
      valid_q <= 1'b0;
      id_q    <= NONE_ID;
      prio_q  <= '0;
    end else if (!valid_q && found) begin
      valid_q <= 1'b1;
      id_q    <= best_id;
      prio_q  <= best_prio;
    end
  end

  assign valid_o = valid_q;
  assign id_o    = id_q;
  assign prio_o  = prio_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int PRIO_W  = 6,
  parameter int THR_W   = 8,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NBANK   = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int SRC_PAD = NBANK * BANK_W;
  localparam int ID_W    = $clog2(NUM_SRC + 1);
  localparam int BSEL_W  = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int NPATH   = 2;

  // ---------------- state ----------------
  logic                          srst_q;
  logic [THR_W-1:0]              thr_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]            route_q;

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0] bank_off, line_off;
  logic              in_bank, in_line;
  logic [BSEL_W-1:0] bank_sel;
  logic [ID_W-1:0]   line_sel;
  bank_sub_e         sub;
  logic              wr_ok;

  assign wr_ok    = reg_wr_i && !srst_q;
  assign bank_off = reg_addr_i - ADDR_W'(BANK_BASE);
  assign line_off = reg_addr_i - ADDR_W'(LINE_BASE);
  assign in_bank  = (reg_addr_i >= ADDR_W'(BANK_BASE)) &&
                    (reg_addr_i <  ADDR_W'(BANK_BASE + NBANK * BANK_STRIDE));
  assign in_line  = (reg_addr_i >= ADDR_W'(LINE_BASE)) &&
                    ((line_off >> 2) < ADDR_W'(NUM_SRC));
  assign bank_sel = in_bank ? BSEL_W'(bank_off >> 5) : '0;
  assign line_sel = in_line ? ID_W'(line_off >> 2) : '0;
  assign sub      = bank_sub_e'(reg_addr_i[4:2]);

  // ---------------- banks ----------------
  logic [SRC_PAD-1:0] src_pad, mask_all, swi_all, act_all;
  assign src_pad = SRC_PAD'(src_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic we_b;
    assign we_b = wr_ok && in_bank && (bank_sel == BSEL_W'(b));
    irqc_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst_q),
      .line_i   (src_pad[b*BANK_W +: BANK_W]),
      .we_i     (we_b),
      .sub_i    (sub),
      .wdata_i  (reg_wdata_i),
      .mask_o   (mask_all[b*BANK_W +: BANK_W]),
      .swi_o    (swi_all[b*BANK_W +: BANK_W]),
      .active_o (act_all[b*BANK_W +: BANK_W])
    );
  end

  // ---------------- pending and eligibility ----------------
  logic [SRC_PAD-1:0]               pend_irq, pend_fiq;
  logic [NPATH-1:0][NUM_SRC-1:0]    path_req;

  always_comb begin
    pend_irq = '0;
    pend_fiq = '0;
    path_req = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      pend_irq[i] = act_all[i] & ~mask_all[i] & ~route_q[i];
      pend_fiq[i] = act_all[i] & ~mask_all[i] &  route_q[i];
      if ((thr_q == '1) || (THR_W'(prio_q[i]) < thr_q)) begin
        path_req[0][i] = pend_irq[i];
        path_req[1][i] = pend_fiq[i];
      end
    end
  end

  // ---------------- sorters ----------------
  logic [NPATH-1:0]             path_valid, path_ack;
  logic [NPATH-1:0][ID_W-1:0]   path_id;
  logic [NPATH-1:0][PRIO_W-1:0] path_prio;

  assign path_ack = (wr_ok && reg_addr_i == ADDR_W'(OFS_CTRL)) ?
                    reg_wdata_i[NPATH-1:0] : '0;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    irqc_sorter #(.N(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sort (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (srst_q),
      .req_i   (path_req[p]),
      .prio_i  (prio_q),
      .ack_i   (path_ack[p]),
      .valid_o (path_valid[p]),
      .id_o    (path_id[p]),
      .prio_o  (path_prio[p])
    );
  end

  assign irq_o = path_valid[0];
  assign fiq_o = path_valid[1];

  // ---------------- control registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= wr_ok && (reg_addr_i == ADDR_W'(OFS_CFG)) && reg_wdata_i[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '1;
      prio_q  <= '0;
      route_q <= '0;
    end else if (srst_q) begin
      thr_q   <= '1;
      prio_q  <= '0;
      route_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == ADDR_W'(OFS_THR)) thr_q <= reg_wdata_i[THR_W-1:0];
      if (in_line) begin
        prio_q[line_sel]  <= reg_wdata_i[PRIO_W+1:2];
        route_q[line_sel] <= reg_wdata_i[0];
      end
    end
  end

  // ---------------- read path ----------------
  logic [REG_W-1:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    if (in_bank) begin
      unique case (sub)
        SUB_RAW:  rd_val = src_pad[bank_sel*BANK_W +: BANK_W];
        SUB_MASK: rd_val = mask_all[bank_sel*BANK_W +: BANK_W];
        SUB_SWI:  rd_val = swi_all[bank_sel*BANK_W +: BANK_W];
        SUB_PIRQ: rd_val = pend_irq[bank_sel*BANK_W +: BANK_W];
        SUB_PFIQ: rd_val = pend_fiq[bank_sel*BANK_W +: BANK_W];
        default:  rd_val = '0;
      endcase
    end else if (in_line) begin
      rd_val[PRIO_W+1:2] = prio_q[line_sel];
      rd_val[0]          = route_q[line_sel];
    end else begin
      unique case (reg_addr_i)
        ADDR_W'(OFS_STAT):    rd_val[0] = !srst_q;
        ADDR_W'(OFS_ACT_IRQ): rd_val[ID_W-1:0] = path_id[0];
        ADDR_W'(OFS_ACT_FIQ): rd_val[ID_W-1:0] = path_id[1];
        ADDR_W'(OFS_THR):     rd_val[THR_W-1:0] = thr_q;
        default:              rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_val;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_SRC = 96,
  parameter int PRIO_W  = 6,
  parameter int THR_W   = 8,
  parameter int ID_W    = 7,
  parameter int SRC_PAD = 96
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    srst_q,
  input logic [1:0]              valid,
  input logic [1:0]              ack,
  input logic [1:0][ID_W-1:0]    id,
  input logic [1:0][PRIO_W-1:0]  win_prio,
  input logic [THR_W-1:0]        thr,
  input logic [1:0][NUM_SRC-1:0] req,
  input logic [SRC_PAD-1:0]      pend_irq,
  input logic [SRC_PAD-1:0]      pend_fiq,
  input logic [SRC_PAD-1:0]      mask
);
  for (genvar p = 0; p < 2; p++) begin : g_p
    // R9
    frozen_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[p] && !ack[p] && !srst_q) |=> (valid[p] && $stable(id[p])));
    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack[p] |=> !valid[p]);
    // R11
    eligible_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid[p] && !ack[p] && !srst_q && (|req[p])) |=> valid[p]);
    // R8
    threshold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid[p]) |-> (($past(thr) == '1) || (THR_W'(win_prio[p]) < $past(thr))));
    // R7
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid[p] |-> (id[p] < ID_W'(NUM_SRC)));
  end

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_irq | pend_fiq) & mask) == '0);
  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && valid == 2'b00));
endmodule

bind irqc_top irqc_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .THR_W(THR_W), .ID_W(ID_W), .SRC_PAD(SRC_PAD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .srst_q   (srst_q),
  .valid    (path_valid),
  .ack      (path_ack),
  .id       (path_id),
  .win_prio (path_prio),
  .thr      (thr_q),
  .req      (path_req),
  .pend_irq (pend_irq),
  .pend_fiq (pend_fiq),
  .mask     (mask_all)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int A_CFG = 'h00, A_STAT = 'h04, A_AIRQ = 'h08, A_AFIQ = 'h0C;
  localparam int A_CTRL = 'h10, A_THR = 'h14;
  localparam int S_RAW = 0, S_MASK = 4, S_MCLR = 8, S_MSET = 'hC;
  localparam int S_SWI = 'h10, S_SCLR = 'h14, S_PIRQ = 'h18, S_PFIQ = 'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  always #2 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr_en), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  bit [5:0]  m_prio [96];
  bit        m_route[96];
  bit [95:0] m_src, m_swi, m_mask;
  bit [7:0]  m_thr;

  function automatic int bank_a(int b, int s);
    return 'h40 + b * 'h20 + s;
  endfunction

  function automatic logic [31:0] exp_win(bit fast);
    int best = 127;
    int bp = 1000;
    for (int i = 0; i < 96; i++) begin
      if ((m_src[i] | m_swi[i]) && !m_mask[i] && m_route[i] == fast &&
          (m_thr == 8'hFF || int'(m_prio[i]) < int'(m_thr)) && int'(m_prio[i]) < bp) begin
        best = i;
        bp = int'(m_prio[i]);
      end
    end
    return 32'(best);
  endfunction

  function automatic logic [31:0] exp_pend(int b, bit fast);
    logic [31:0] v = '0;
    for (int j = 0; j < 32; j++) begin
      int n = b * 32 + j;
      v[j] = (m_src[n] | m_swi[n]) & ~m_mask[n] & (m_route[n] == fast);
    end
    return v;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; addr = 10'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(int a, logic [31:0] exp, string r);
    @(negedge clk);
    addr = 10'(a);
    @(negedge clk);
    chk(r, rdata, exp);
  endtask

  task automatic set_line(int n, int pr, bit fast);
    wr('h100 + 4 * n, 32'((pr << 2) | int'(fast)));
    m_prio[n] = 6'(pr);
    m_route[n] = fast;
  endtask

  task automatic drive_src();
    src = m_src;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    logic [31:0] rv;
    seed_v = $urandom(32'd20240611);
    m_src = '0; m_swi = '0; m_mask = '1; m_thr = 8'hFF;
    for (int i = 0; i < 96; i++) begin m_prio[i] = '0; m_route[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 irq_o", 32'(irq), 0);
    chk("R13 fiq_o", 32'(fiq), 0);
    rdchk(A_STAT, 1, "R13 status");
    rdchk(A_AIRQ, 127, "R13 active irq");
    rdchk(A_AFIQ, 127, "R13 active fiq");
    rdchk('h100 + 4 * 5, 0, "R13 line");
    rdchk(bank_a(0, S_MASK), 32'hFFFF_FFFF, "R2 mask reset");
    rdchk(A_THR, 32'hFF, "R8 threshold reset");

    // R1 raw, R2 masked quiet
    m_src[70] = 1; m_src[95] = 1; drive_src();
    rdchk(bank_a(2, S_RAW), 32'h8000_0040, "R1 raw");
    rdchk(bank_a(2, S_PIRQ), 0, "R2 masked pending");
    chk("R2 masked output", 32'(irq), 0);
    m_src = '0; drive_src();

    // R3 aliases
    wr(bank_a(0, S_MCLR), 32'h0000_F0F0);
    rdchk(bank_a(0, S_MASK), 32'hFFFF_0F0F, "R3 clear alias");
    wr(bank_a(0, S_MSET), 32'h0000_0010);
    rdchk(bank_a(0, S_MASK), 32'hFFFF_0F1F, "R3 set alias");
    rdchk(bank_a(0, S_MCLR), 0, "R3 alias reads zero");
    wr(bank_a(0, S_MSET), 32'hFFFF_FFFF);

    // R6 line layout
    wr('h100 + 4 * 7, 32'hFFFF_FFFF);
    rdchk('h100 + 4 * 7, 32'h0000_00FD, "R6 line fields");
    set_line(7, 0, 0);

    // R7 tie, R10 ack timing, R9 freeze
    wr(bank_a(1, S_MCLR), 32'hFFFF_FFFF); m_mask[63:32] = '0;
    set_line(40, 2, 0); set_line(41, 2, 0); set_line(50, 1, 0);
    m_src[40] = 1; m_src[41] = 1; drive_src();
    rdchk(A_AIRQ, 40, "R7 tie lower index");
    chk("R11 irq_o", 32'(irq), 1);
    wr(A_CTRL, 1);
    chk("R10 drop after ack", 32'(irq), 0);
    @(negedge clk);
    chk("R10 re-raise", 32'(irq), 1);
    m_src[50] = 1; drive_src();
    rdchk(A_AIRQ, 40, "R9 frozen on better source");
    m_src[40] = 0; m_src[41] = 0; drive_src();
    rdchk(A_AIRQ, 40, "R9 frozen on source drop");
    chk("R9 output held", 32'(irq), 1);
    wr(A_CTRL, 1);
    rdchk(A_AIRQ, 50, "R7 new winner after ack");

    // R8 threshold boundary
    wr(A_THR, 1); m_thr = 1;
    wr(A_CTRL, 1);
    rdchk(A_AIRQ, 127, "R8 equal to threshold blocked");
    chk("R8 irq_o low", 32'(irq), 0);
    wr(A_THR, 2); m_thr = 2;
    rdchk(A_AIRQ, 50, "R8 below threshold passes");
    wr(A_THR, 'hFF); m_thr = 8'hFF;

    // R5 fast path
    set_line(60, 0, 1);
    m_src = '0; m_src[60] = 1; drive_src();
    wr(A_CTRL, 3);
    rdchk(A_AFIQ, 60, "R5 fast winner");
    rdchk(A_AIRQ, 127, "R5 normal idle");
    rdchk(bank_a(1, S_PFIQ), 32'h1000_0000, "R5 pending fast");
    rdchk(bank_a(1, S_PIRQ), 0, "R5 pending normal");
    chk("R5 fiq_o", 32'(fiq), 1);
    chk("R5 irq_o", 32'(irq), 0);
    wr(A_CTRL, 2);
    chk("R10 fast drop", 32'(fiq), 0);
    m_src = '0; drive_src();
    wr(A_CTRL, 3);

    // R4 software interrupt
    set_line(37, 3, 0);
    wr(bank_a(1, S_SWI), 32'h20); m_swi[37] = 1;
    rdchk(bank_a(1, S_SWI), 32'h20, "R4 swi readback");
    rdchk(A_AIRQ, 37, "R4 swi winner");
    wr(bank_a(1, S_SCLR), 32'h20); m_swi[37] = 0;
    wr(A_CTRL, 1);
    rdchk(A_AIRQ, 127, "R4 swi cleared");
    chk("R4 irq_o", 32'(irq), 0);

    // random mix
    for (int it = 0; it < 20; it++) begin
      m_src = {$urandom, $urandom, $urandom};
      drive_src();
      for (int n = 0; n < 96; n++) set_line(n, int'($urandom % 4), ($urandom % 4) == 0);
      for (int b = 0; b < 3; b++) begin
        wr(bank_a(b, S_MSET), 32'hFFFF_FFFF);
        rv = $urandom;
        wr(bank_a(b, S_MCLR), rv);
        m_mask[b*32 +: 32] = ~rv;
        wr(bank_a(b, S_SCLR), 32'hFFFF_FFFF);
        rv = $urandom & $urandom & $urandom;
        wr(bank_a(b, S_SWI), rv);
        m_swi[b*32 +: 32] = rv;
      end
      case ($urandom % 3)
        0: m_thr = 8'hFF;
        1: m_thr = 8'd2;
        default: m_thr = 8'd3;
      endcase
      wr(A_THR, 32'(m_thr));
      wr(A_CTRL, 3);
      rdchk(A_AIRQ, exp_win(0), "R7 random normal winner");
      rdchk(A_AFIQ, exp_win(1), "R7 random fast winner");
      chk("R11 random irq_o", 32'(irq), 32'(exp_win(0) != 127));
      chk("R11 random fiq_o", 32'(fiq), 32'(exp_win(1) != 127));
      for (int b = 0; b < 3; b++) begin
        rdchk(bank_a(b, S_PIRQ), exp_pend(b, 0), "R5 random pending normal");
        rdchk(bank_a(b, S_PFIQ), exp_pend(b, 1), "R5 random pending fast");
      end
    end

    // R12 soft reset
    wr(A_CFG, 2);
    addr = 10'(A_STAT);
    @(negedge clk);
    chk("R12 status busy", rdata, 0);
    rdchk(A_STAT, 1, "R12 status done");
    rdchk(bank_a(1, S_MASK), 32'hFFFF_FFFF, "R12 mask restored");
    rdchk(bank_a(1, S_SWI), 0, "R12 swi cleared");
    rdchk(A_THR, 32'hFF, "R12 threshold restored");
    rdchk('h100 + 4 * 37, 0, "R12 line restored");
    rdchk(A_AIRQ, 127, "R12 winner cleared");
    chk("R12 irq_o", 32'(irq), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule